// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block holds the 32-bit control registers of a DRAM controller behind a word-addressed read/write port. Writes pass through a three-state protection scheme. A software unlock key opens the bank. A second key freezes it until the next reset. Any other value written to the protection word drops it back to a soft lock. A fixed list of words stays writable whatever the lock state, so interrupt, test and timing words can be reached without unlocking.

Several words reshape the data written to them. In the configuration word, the read-only fields are re-imposed on every write: the hardware version, the aperture bits and a memory-size code. The size code comes from a parameter. The PHY status word and the ECC test control word force their done and fail bits, so polling software always sees a finished, healthy result. Reads are registered and take one cycle. A blocked write raises a one-cycle flag.

Top module: `keylock_regbank`

## Requirements
- R1: Writing 32'hFC600309 to word 0 (the protection word) while not hard-locked makes word 0 read 32'h00000001, and all words then accept writes.
- R2: Writing 32'hDEADDEAD to word 0 while not hard-locked makes word 0 read 32'h00000010. From then until reset, every write to a word outside the exempt list, word 0 included, is dropped.
- R3: Writing any other value to word 0 while not hard-locked makes it read 32'h00000000 (soft lock). While soft-locked, writes to protected words other than word 0 are dropped, and writes to word 0 are still taken.
- R4: Words 20, 27, 29, 30, 31, 34, 35 and 45 (byte offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C, 0xB4) store any write unchanged in every lock state.
- R5: Word 1 (configuration) stores the write data with bits 31:28, 19:14, 6 and 3:0 replaced. Bits 31:28 become HW_VER, bit 19, bits 18:14 and bit 6 become 0, bits 3:2 become 2'b11 and bits 1:0 become the size code.
- R6: The size code is the position of MEM_MBYTES in the ordered list 256, 512, 1024, 2048. The default of 1024 gives 2'b10.
- R7: A write to word 24 (byte 0x60) stores the data with bit 0 cleared and bit 4 set.
- R8: A write to word 28 (byte 0x70) stores the data with bit 12 set and bit 13 cleared.
- R9: After reset, word 0 reads 0 (soft lock), word 1 holds only its fixed fields (32'h3000000E by default), all other words read 0, and rd_valid and wr_blocked are low.
- R10: A read at a word address of NUM_WORDS or above returns 0. A write there changes nothing and does not raise wr_blocked.
- R11: wr_blocked is high for exactly the one cycle after a write that the lock state dropped, and low otherwise.
- R12: rdata and rd_valid appear one cycle after rd_en, giving the value before any write in the same cycle. A read never changes the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one full word |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address (byte offset divided by 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after rd_en |
| wr_blocked | output | 1 | One-cycle pulse after a write dropped by the lock |

## Verification
Read data and rd_valid are due one clock after the strobe. wr_blocked is also due one clock after the write it refers to. A stored value or a new lock state first shows up in a read issued in the next cycle. The bench drives each stimulus at the falling edge and forms the expected outputs from its behavioural model before the rising edge. It compares them 5 ns after that edge, every cycle. The model works out the read value before it applies a write from the same cycle, which matches the read-before-write order of R12.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

   typedef enum logic [7:0] {
      LK_SOFT = 8'h00,
      LK_OPEN = 8'h01,
      LK_HARD = 8'h10
   } lock_e;

   localparam logic [31:0] KEY_OPEN = 32'hFC60_0309;
   localparam logic [31:0] KEY_HARD = 32'hDEAD_DEAD;

   // word indices whose write behaviour is special
   localparam int unsigned W_PROT = 0;
   localparam int unsigned W_CFG  = 1;
   localparam int unsigned W_STAT = 24;
   localparam int unsigned W_ECCT = 28;
   localparam int unsigned W_MIN  = 46;   // smallest bank that holds every special word

   // configuration bits replaced on every write (version, init-done, reserved, compat, aperture, size)
   localparam logic [31:0] CFG_RO_MASK = 32'hF00F_C04F;

   localparam logic [31:0] STAT_BUSY  = 32'h0000_0001;
   localparam logic [31:0] STAT_PLL   = 32'h0000_0010;
   localparam logic [31:0] ECCT_DONE  = 32'h0000_1000;
   localparam logic [31:0] ECCT_FAIL  = 32'h0000_2000;

   function automatic bit size_is_legal(int mb);
      return (mb == 256) || (mb == 512) || (mb == 1024) || (mb == 2048);
   endfunction

   function automatic logic [1:0] size_code(int mb);
      logic [1:0] c;
      c = 2'd0;
      for (int i = 0; i < 4; i++) begin
         if (mb == (256 << i)) c = 2'(i);
      end
      return c;
   endfunction

   function automatic logic [31:0] cfg_fixed(int ver, int mb);
      logic [31:0] v;
      v = 32'(ver & 15) << 28;
      return v | 32'h0000_000C | {30'b0, size_code(mb)};
   endfunction

   function automatic bit is_exempt(int unsigned w);
      case (w)
         20, 27, 29, 30, 31, 34, 35, 45: return 1'b1;
         default:                        return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/keylock_lock_fsm.sv
module keylock_lock_fsm
   import keylock_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_wr,
   input  logic [31:0] key,
   output lock_e       state
);

   lock_e state_nx;

   always_comb begin
      state_nx = state;
      if (key_wr) begin
         if (key == KEY_OPEN)      state_nx = LK_OPEN;
         else if (key == KEY_HARD) state_nx = LK_HARD;
         else                      state_nx = LK_SOFT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= LK_SOFT;
      else        state <= state_nx;
   end

endmodule

// File: rtl/keylock_wr_filter.sv
module keylock_wr_filter
   import keylock_pkg::*;
#(
   parameter int          ADDR_W          = 10,
   parameter int          NUM_WORDS       = 64,
   parameter logic [31:0] CFG_FIXED       = 32'h3000_000E,
   parameter bit          STAT_FORCE_LOCK = 1'b1
)(
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  lock_e             lock,
   output logic              commit,
   output logic              key_wr,
   output logic              blocked,
   output logic [31:0]       shaped
);

   logic          in_rng;
   logic          exempt;
   logic          is_prot;
   logic          allowed;
   int unsigned   widx;
   logic [31:0]   stat_data;

   assign in_rng  = {1'b0, addr} < (ADDR_W+1)'(NUM_WORDS);
   assign widx    = 32'(addr);
   assign exempt  = is_exempt(widx);
   assign is_prot = (widx == W_PROT);

   always_comb begin
      case (lock)
         LK_OPEN: allowed = 1'b1;
         LK_SOFT: allowed = exempt || is_prot;
         default: allowed = exempt;
      endcase
   end

   assign key_wr  = wr_en && in_rng && is_prot && allowed;
   assign commit  = wr_en && in_rng && !is_prot && allowed;
   assign blocked = wr_en && in_rng && !allowed;

   generate
      if (STAT_FORCE_LOCK) begin : g_stat_pll
         assign stat_data = (wdata & ~STAT_BUSY) | STAT_PLL;
      end else begin : g_stat_plain
         assign stat_data = wdata & ~STAT_BUSY;
      end
   endgenerate

   always_comb begin
      shaped = wdata;
      if (!exempt) begin
         case (widx)
            W_CFG:   shaped = (wdata & ~CFG_RO_MASK) | CFG_FIXED;
            W_STAT:  shaped = stat_data;
            W_ECCT:  shaped = (wdata | ECCT_DONE) & ~ECCT_FAIL;
            default: shaped = wdata;
         endcase
      end
   end

endmodule

// File: rtl/keylock_reg_array.sv
module keylock_reg_array #(
   parameter int          NUM_WORDS = 64,
   parameter int          IDX_W     = 6,
   parameter logic [31:0] CFG_RESET = 32'h3000_000E
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [IDX_W-1:0]         widx,
   input  logic [31:0]              wd,
   output logic [NUM_WORDS*32-1:0]  words
);

   generate
      for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
         if (g == 0) begin : g_prot_slot
            // protection word lives in the lock state machine
            assign words[31:0] = '0;
         end else begin : g_store
            localparam logic [31:0] RST_VAL = (g == 1) ? CFG_RESET : 32'h0;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                            words[g*32 +: 32] <= RST_VAL;
               else if (we && widx == IDX_W'(g))      words[g*32 +: 32] <= wd;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/keylock_regbank.sv
module keylock_regbank
   import keylock_pkg::*;
#(
   parameter int ADDR_W          = 10,
   parameter int NUM_WORDS       = 64,
   parameter int HW_VER          = 3,
   parameter int MEM_MBYTES      = 1024,
   parameter bit STAT_FORCE_LOCK = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              rd_valid,
   output logic              wr_blocked
);

   localparam int          IDX_W     = $clog2(NUM_WORDS);
   localparam logic [31:0] CFG_FIXED = cfg_fixed(HW_VER, MEM_MBYTES);

   generate
      if (!size_is_legal(MEM_MBYTES)) begin : g_bad_size
         $error("MEM_MBYTES must be 256, 512, 1024 or 2048");
      end
      if (NUM_WORDS < int'(W_MIN) || NUM_WORDS > (1 << ADDR_W)) begin : g_bad_depth
         $error("NUM_WORDS must cover the special words and fit in ADDR_W");
      end
      if (HW_VER < 0 || HW_VER > 15) begin : g_bad_ver
         $error("HW_VER must fit in four bits");
      end
   endgenerate

   lock_e                    lock_q;
   logic [7:0]               lock_code;
   logic                     commit;
   logic                     key_wr;
   logic                     blocked;
   logic [31:0]              shaped;
   logic [NUM_WORDS*32-1:0]  words;
   logic [31:0]              cfg_word;
   logic [IDX_W-1:0]         idx;
   logic                     rd_in_rng;
   logic [31:0]              rd_word;

   assign idx       = addr[IDX_W-1:0];
   assign lock_code = lock_q;
   assign cfg_word  = words[63:32];

   keylock_wr_filter #(
      .ADDR_W          (ADDR_W),
      .NUM_WORDS       (NUM_WORDS),
      .CFG_FIXED       (CFG_FIXED),
      .STAT_FORCE_LOCK (STAT_FORCE_LOCK)
   ) filt_i (
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .lock    (lock_q),
      .commit  (commit),
      .key_wr  (key_wr),
      .blocked (blocked),
      .shaped  (shaped)
   );

   keylock_lock_fsm lock_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .key_wr (key_wr),
      .key    (wdata),
      .state  (lock_q)
   );

   keylock_reg_array #(
      .NUM_WORDS (NUM_WORDS),
      .IDX_W     (IDX_W),
      .CFG_RESET (CFG_FIXED)
   ) regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (commit),
      .widx  (idx),
      .wd    (shaped),
      .words (words)
   );

   assign rd_in_rng = {1'b0, addr} < (ADDR_W+1)'(NUM_WORDS);

   always_comb begin
      if (!rd_in_rng)      rd_word = '0;
      else if (idx == '0)  rd_word = {24'b0, lock_code};
      else                 rd_word = words[{idx, 5'b0} +: 32];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata      <= '0;
         rd_valid   <= 1'b0;
         wr_blocked <= 1'b0;
      end else begin
         rd_valid   <= rd_en;
         wr_blocked <= blocked;
         if (rd_en) rdata <= rd_word;
      end
   end

endmodule

// File: rtl/keylock_regbank_chk.sv
module keylock_regbank_chk #(
   parameter int ADDR_W    = 10,
   parameter int NUM_WORDS = 64,
   parameter int HW_VER    = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       rdata,
   input logic              rd_valid,
   input logic              wr_blocked,
   input logic [7:0]        lock_code,
   input logic [31:0]       cfg_word
);

   logic oob;
   assign oob = {1'b0, addr} >= (ADDR_W+1)'(NUM_WORDS);

   // R2
   hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_code == 8'h10 |=> lock_code == 8'h10);

   // R2
   hard_key_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock_code == 8'h10 && addr == '0) |=> wr_blocked);

   // R12
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // R12
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R12
   read_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en) |=> $stable(lock_code));

   // R10
   oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && oob) |=> rdata == 32'h0);

   // R10
   oob_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && oob) |=> !wr_blocked);

   // R5
   cfg_version_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_word[31:28] == 4'(HW_VER) && cfg_word[3:2] == 2'b11);

endmodule

bind keylock_regbank keylock_regbank_chk #(
   .ADDR_W    (ADDR_W),
   .NUM_WORDS (NUM_WORDS),
   .HW_VER    (HW_VER)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .addr       (addr),
   .rdata      (rdata),
   .rd_valid   (rd_valid),
   .wr_blocked (wr_blocked),
   .lock_code  (lock_code),
   .cfg_word   (cfg_word)
);

// File: tb/keylock_regbank_tb_top.sv
`timescale 1ns/1ps
module keylock_regbank_tb_top;

   localparam int AW = 10;
   localparam int NW = 64;
   localparam int HV = 3;
   localparam int MB = 1024;
   localparam logic [31:0] K_OPEN = 32'hFC60_0309;
   localparam logic [31:0] K_HARD = 32'hDEAD_DEAD;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          rd_valid;
   logic          wr_blocked;

   always #10 clk = ~clk;

   keylock_regbank #(.ADDR_W(AW), .NUM_WORDS(NW), .HW_VER(HV), .MEM_MBYTES(MB)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .wr_blocked(wr_blocked)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [31:0] m_mem [NW];
   logic [7:0]  m_lock;
   logic [31:0] m_fixed;

   function automatic logic [31:0] fixed_fields();
      int code;
      code = 0;
      for (int i = 0; i < 4; i++) if (MB == (256 << i)) code = i;
      return (32'(HV) << 28) | 32'h0000_000C | 32'(code);
   endfunction

   function automatic bit m_exempt(int w);
      return w == 20 || w == 27 || w == 29 || w == 30 || w == 31 ||
             w == 34 || w == 35 || w == 45;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NW; i++) m_mem[i] = 32'h0;
      m_fixed  = fixed_fields();
      m_mem[1] = m_fixed;
      m_lock   = 8'h00;
   endtask

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // one bus cycle: drive at falling edge, compare 5 ns after the next rising edge
   task automatic cyc(bit we, bit re, int a, logic [31:0] d, string tag);
      bit          e_valid;
      bit          e_blk;
      logic [31:0] e_rdata;
      wr_en = we; rd_en = re; addr = a[AW-1:0]; wdata = d;
      e_valid = re;
      e_blk   = 1'b0;
      e_rdata = (a < NW) ? ((a == 0) ? {24'b0, m_lock} : m_mem[a]) : 32'h0;
      if (we && a < NW) begin
         if (m_exempt(a)) m_mem[a] = d;
         else if (m_lock == 8'h10 || (m_lock == 8'h00 && a != 0)) e_blk = 1'b1;
         else if (a == 0) m_lock = (d == K_OPEN) ? 8'h01 : (d == K_HARD) ? 8'h10 : 8'h00;
         else if (a == 1) m_mem[a] = (d & 32'h0FF0_3FB0) | m_fixed;
         else if (a == 24) m_mem[a] = (d & ~32'h1) | 32'h10;
         else if (a == 28) m_mem[a] = (d | 32'h1000) & ~32'h2000;
         else m_mem[a] = d;
      end
      @(posedge clk); #5;
      check({tag, " rd_valid"}, 32'(rd_valid), 32'(e_valid));
      check({tag, " wr_blocked"}, 32'(wr_blocked), 32'(e_blk));
      if (e_valid) check({tag, " rdata"}, rdata, e_rdata);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic do_reset(string tag);
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      check({tag, " reset rd_valid"}, 32'(rd_valid), 32'h0);
      check({tag, " reset wr_blocked"}, 32'(wr_blocked), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R12 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int ex_list [8] = '{20, 27, 29, 30, 31, 34, 35, 45};
      int pool [12]   = '{0, 1, 2, 5, 20, 24, 28, 45, 63, 64, 100, 35};
      model_reset();
      @(negedge clk);
      do_reset("R9");

      // R9 reset contents, R6 size code, R5 fixed fields
      cyc(0, 1, 1, 0, "R9 cfg after reset");
      check("R6 size code", 32'(rdata[1:0]), 32'd2);
      check("R5 aperture", 32'(rdata[3:2]), 32'd3);
      cyc(0, 1, 0, 0, "R9 prot after reset");
      cyc(0, 1, 2, 0, "R9 plain word after reset");

      // R3 soft lock drops protected writes
      cyc(1, 0, 2, 32'h1234_5678, "R3 soft write blocked");
      cyc(0, 1, 2, 0, "R3 soft readback");
      // R11 no pulse on idle cycle
      cyc(0, 0, 0, 0, "R11 idle");

      // R4 exempt words while soft-locked
      foreach (ex_list[i]) begin
         cyc(1, 0, ex_list[i], 32'hA500_0000 + 32'(i), "R4 exempt write soft");
         cyc(0, 1, ex_list[i], 0, "R4 exempt read soft");
      end

      // R1 unlock
      cyc(1, 0, 0, K_OPEN, "R1 unlock");
      cyc(0, 1, 0, 0, "R1 prot reads open");
      cyc(1, 0, 2, 32'hCAFE_F00D, "R1 open write");
      cyc(0, 1, 2, 0, "R1 open readback");

      // R5 configuration merge
      cyc(1, 0, 1, 32'hFFFF_FFFF, "R5 cfg ones");
      cyc(0, 1, 1, 0, "R5 cfg ones readback");
      cyc(1, 0, 1, 32'h0000_0000, "R5 cfg zeros");
      cyc(0, 1, 1, 0, "R5 cfg zeros readback");

      // R7 and R8 status shaping
      cyc(1, 0, 24, 32'hFFFF_FFFF, "R7 status ones");
      cyc(0, 1, 24, 0, "R7 status readback");
      cyc(1, 0, 24, 32'h0, "R7 status zeros");
      cyc(0, 1, 24, 0, "R7 status zeros readback");
      cyc(1, 0, 28, 32'hFFFF_FFFF, "R8 ecc ones");
      cyc(0, 1, 28, 0, "R8 ecc readback");
      cyc(1, 0, 28, 32'h0, "R8 ecc zeros");
      cyc(0, 1, 28, 0, "R8 ecc zeros readback");

      // R10 out of range
      cyc(1, 0, 100, 32'hFFFF_FFFF, "R10 oob write");
      cyc(0, 1, 100, 0, "R10 oob read");
      cyc(0, 1, 64, 0, "R10 first oob word");
      cyc(0, 1, 63, 0, "R10 last word in range");

      // R12 read and write same cycle returns old value
      cyc(1, 1, 2, 32'h0BAD_BEEF, "R12 read before write");
      cyc(0, 1, 2, 0, "R12 new value");

      // R3 relock with arbitrary value, R11 blocked pulse
      cyc(1, 0, 0, 32'h0000_1234, "R3 relock");
      cyc(0, 1, 0, 0, "R3 prot soft");
      cyc(1, 0, 3, 32'h1, "R11 blocked pulse");
      cyc(0, 1, 3, 0, "R11 readback after block");

      // R2 hard lock
      cyc(1, 0, 0, K_HARD, "R2 hard lock");
      cyc(0, 1, 0, 0, "R2 prot hard");
      cyc(1, 0, 0, K_OPEN, "R2 unlock ignored");
      cyc(0, 1, 0, 0, "R2 still hard");
      cyc(1, 0, 1, 32'h0, "R2 cfg blocked");
      cyc(1, 0, 2, 32'h0, "R2 word blocked");
      cyc(0, 1, 2, 0, "R2 word kept");
      cyc(1, 0, 45, 32'h7777_0000, "R4 exempt under hard lock");
      cyc(0, 1, 45, 0, "R4 exempt readback hard");
      cyc(0, 1, 0, 0, "R12 read keeps lock");
      cyc(0, 1, 0, 0, "R12 read keeps lock again");

      // R9 reset clears hard lock
      do_reset("R9");
      cyc(0, 1, 0, 0, "R9 prot soft after reset");
      cyc(0, 1, 45, 0, "R9 exempt cleared");
      cyc(0, 1, 1, 0, "R9 cfg fixed");

      // mixed traffic against the model
      for (int n = 0; n < 600; n++) begin
         int          a;
         logic [31:0] d;
         int          sel;
         a   = pool[$urandom_range(0, 11)];
         sel = $urandom_range(0, 3);
         d   = (sel == 0) ? K_OPEN : (sel == 1 && n % 5 == 0) ? K_HARD : $urandom;
         cyc(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), a, d, "R12 mixed");
         if (n % 97 == 96) do_reset("R9");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule